// File: doc/BRIEF.md
# Crest Factor Over-Current Detector

This block watches digitized samples of the low-side switch current in a half-bridge. The samples are taken only while that switch conducts. For each switching cycle it keeps the largest valid sample. Across all cycles it keeps an exponential moving average of the same samples. When a cycle closes, it compares that cycle's peak with the average. If the peak is more than 5.5 times the average, it latches an over-current fault. Because the test is a ratio, a change in the gain of the sense element scales both sides equally and does not move the trip point. A saturating resonant inductor is the typical condition this detects.

The mode controller holds `en_i` high only during the steady dimming phase. While `en_i` is low, nothing is evaluated, the average is held at zero and the cycle peak is cleared. After each enable, a warm-up count of cycle boundaries has to pass before any comparison may trip. This keeps a cold average from causing a false fault. The fault flag is sticky and is cleared only by reset. The mode controller uses it to shut the outputs down.

Top module: `crest_fault_detector`

## Requirements
- R1: While reset is low, and in the first clock after reset is released, `fault_o` is 0.
- R2: At a clock edge where `en_i` and `cyc_end_i` are both 1 and the detector is armed, a fault is latched when 2·peak > 11·avg. Here avg is the average held before that edge. `fault_o` rises one clock after that edge. If 2·peak equals 11·avg, there is no trip.
- R3: The peak is the largest `smp_i` with `smp_valid_i` = 1 in the current cycle. A sample presented on the same edge as `cyc_end_i` counts towards the cycle it closes. Samples with `smp_valid_i` = 0 are ignored.
- R4: The peak is cleared at every cycle boundary, so a large sample in one cycle cannot trip a later cycle.
- R5: The average is an unsigned accumulator `acc += sample − (acc >> AVG_SHIFT)`, updated on each valid sample, with avg = `acc >> AVG_SHIFT`. For a constant input v it settles to exactly v. It is held at zero while `en_i` is 0.
- R6: The detector becomes armed only once MIN_CYCLES boundaries have occurred with `en_i` high since the last enable. Boundaries before that never trip. With the default MIN_CYCLES = 4, the fifth boundary is the first one evaluated.
- R7: While `en_i` is 0, samples and boundaries have no effect, and no fault can be latched.
- R8: Once `fault_o` is 1, it stays 1 until reset, whatever the inputs do.
- R9: The trip point follows the ratio only. Scaling every sample by a common factor scales the trip peak by the same factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Detection enable (dimming phase only) |
| smp_valid_i | input | 1 | Qualifies `smp_i` |
| smp_i | input | SAMPLE_W | Unsigned low-side current sample |
| cyc_end_i | input | 1 | Switching cycle boundary strobe |
| fault_o | output | 1 | Sticky over-current fault |

## Verification
The only result is `fault_o`. It is due one clock after the edge that carries the closing `cyc_end_i`. The bench drives every input on the falling edge and reads `fault_o` at the falling edge after that boundary. It checks after every boundary whose outcome matters, including each warm-up boundary. The average is brought to a known exact value before each threshold test: a long run of constant samples, with the trial peak placed on the boundary edge itself. Equality and one-above are then both compared at two sample scales.

// File: rtl/cfd_pkg.sv
// Shared helpers for the crest factor detector.
// Assumes unsigned samples and small positive ratio constants.
package cfd_pkg;

    // Default ratio: trip when CF_DEN*peak > CF_NUM*avg (5.5 = 11/2).
    localparam int unsigned CF_NUM_DEF = 11;
    localparam int unsigned CF_DEN_DEF = 2;

    // Bit width needed to hold value*k for a w-bit unsigned value.
    function automatic int unsigned prod_width(input int unsigned w, input int unsigned k);
        return w + $clog2(k + 1);
    endfunction

endpackage

// File: rtl/cfd_peak_track.sv
// Per-cycle peak tracker.
// Keeps the largest valid sample since the last cycle boundary. The
// combinational output includes a sample arriving on the boundary edge
// itself. The stored peak is cleared at each boundary and while disabled.
module cfd_peak_track #(
    parameter int unsigned SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic                cyc_end_i,
    output logic [SAMPLE_W-1:0] peak_now_o
);
    logic [SAMPLE_W-1:0] run_q;
    logic [SAMPLE_W-1:0] cand;

    // Merge the incoming sample into the running maximum.
    always_comb begin
        cand = run_q;
        if (smp_valid_i && (smp_i > run_q)) begin
            cand = smp_i;
        end
    end

    assign peak_now_o = cand;

    // Store the running maximum; restart at each boundary or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            run_q <= '0;
        end else if (cyc_end_i) begin
            run_q <= '0;
        end else begin
            run_q <= cand;
        end
    end
endmodule

// File: rtl/cfd_avg_filter.sv
// Exponential moving average of valid samples.
// acc holds avg scaled by 2^AVG_SHIFT. Each valid sample does
// acc = acc - (acc >> AVG_SHIFT) + sample. The accumulator stays below
// 2^(SAMPLE_W+AVG_SHIFT), and a constant input v settles to avg == v.
// Held at zero while disabled.
module cfd_avg_filter #(
    parameter int unsigned SAMPLE_W  = 12,
    parameter int unsigned AVG_SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_i,
    output logic [SAMPLE_W-1:0] avg_o
);
    localparam int unsigned ACC_W = SAMPLE_W + AVG_SHIFT;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_nxt;

    // Leaky integrator step, one guard bit against intermediate carry.
    always_comb begin
        acc_nxt = {1'b0, acc_q} - {1'b0, (acc_q >> AVG_SHIFT)}
                + {{(AVG_SHIFT + 1){1'b0}}, smp_i};
    end

    // Update on each valid sample; forced to zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            acc_q <= '0;
        end else if (smp_valid_i) begin
            acc_q <= acc_nxt[ACC_W-1:0];
        end
    end

    assign avg_o = acc_q[ACC_W-1:AVG_SHIFT];
endmodule

// File: rtl/cfd_warmup.sv
// Warm-up gate: counts cycle boundaries seen with enable high and raises
// armed_o once MIN_CYCLES have passed. Restarts whenever enable drops.
module cfd_warmup #(
    parameter int unsigned MIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic cyc_end_i,
    output logic armed_o
);
    localparam int unsigned CNT_W = $clog2(MIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Saturating boundary counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
        end else if (cyc_end_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign armed_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/cfd_ratio_cmp.sv
// Division-free ratio comparator: gt_o = CF_DEN*peak > CF_NUM*avg.
// Both products are widened so neither can overflow.
module cfd_ratio_cmp
    import cfd_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned CF_NUM   = CF_NUM_DEF,
    parameter int unsigned CF_DEN   = CF_DEN_DEF
) (
    input  logic [SAMPLE_W-1:0] peak_i,
    input  logic [SAMPLE_W-1:0] avg_i,
    output logic                gt_o
);
    localparam int unsigned KMAX   = (CF_NUM > CF_DEN) ? CF_NUM : CF_DEN;
    localparam int unsigned PROD_W = prod_width(SAMPLE_W, KMAX);

    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;

    // Scale both sides into a common width and compare.
    always_comb begin
        lhs  = PROD_W'(peak_i) * PROD_W'(CF_DEN);
        rhs  = PROD_W'(avg_i) * PROD_W'(CF_NUM);
        gt_o = (lhs > rhs);
    end
endmodule

// File: rtl/crest_fault_detector.sv
// Crest factor over-current detector, top level.
// Tracks the per-cycle peak and a running average of low-side current
// samples. At each armed, enabled cycle boundary it latches a sticky
// fault when the peak exceeds the average by the crest ratio.
// Assumes samples arrive only while the low-side switch conducts, and
// that en_i is high only in the dimming phase.
module crest_fault_detector
    import cfd_pkg::*;
#(
    parameter int unsigned SAMPLE_W   = 12,
    parameter int unsigned AVG_SHIFT  = 3,
    parameter int unsigned MIN_CYCLES = 4,
    parameter int unsigned CF_NUM     = CF_NUM_DEF,
    parameter int unsigned CF_DEN     = CF_DEN_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic                cyc_end_i,
    output logic                fault_o
);
    logic [SAMPLE_W-1:0] peak_now;
    logic [SAMPLE_W-1:0] avg_q;
    logic                armed;
    logic                ratio_gt;
    logic                fault_q;

    cfd_peak_track #(.SAMPLE_W(SAMPLE_W)) u_peak (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .smp_valid_i(smp_valid_i),
        .smp_i      (smp_i),
        .cyc_end_i  (cyc_end_i),
        .peak_now_o (peak_now)
    );

    cfd_avg_filter #(.SAMPLE_W(SAMPLE_W), .AVG_SHIFT(AVG_SHIFT)) u_avg (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .smp_valid_i(smp_valid_i),
        .smp_i      (smp_i),
        .avg_o      (avg_q)
    );

    cfd_warmup #(.MIN_CYCLES(MIN_CYCLES)) u_warm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .cyc_end_i(cyc_end_i),
        .armed_o  (armed)
    );

    cfd_ratio_cmp #(.SAMPLE_W(SAMPLE_W), .CF_NUM(CF_NUM), .CF_DEN(CF_DEN)) u_cmp (
        .peak_i(peak_now),
        .avg_i (avg_q),
        .gt_o  (ratio_gt)
    );

    // Sticky fault latch, set only at an armed, enabled boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (en_i && cyc_end_i && armed && ratio_gt) begin
            fault_q <= 1'b1;
        end
    end

    assign fault_o = fault_q;
endmodule

// File: rtl/cfd_checker.sv
// Property checker for crest_fault_detector. Keeps its own count of
// enabled boundaries so that it does not rely on the warm-up logic.
module cfd_checker #(
    parameter int unsigned SAMPLE_W   = 12,
    parameter int unsigned MIN_CYCLES = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en_i,
    input logic                cyc_end_i,
    input logic                fault_o,
    input logic [SAMPLE_W-1:0] avg_q
);
    localparam int unsigned CW = $clog2(MIN_CYCLES + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_CYCLES);

    logic [CW-1:0] seen_q;

    // Independent count of enabled boundaries since the last enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            seen_q <= '0;
        end else if (cyc_end_i && (seen_q != CMAX)) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !fault_o);

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);

    // R2
    rise_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(cyc_end_i));

    // R6
    rise_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> ($past(seen_q) == CMAX));

    // R7
    rise_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(en_i));

    // R5
    avg_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (avg_q == '0));
endmodule

bind crest_fault_detector cfd_checker #(
    .SAMPLE_W  (SAMPLE_W),
    .MIN_CYCLES(MIN_CYCLES)
) u_cfd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .cyc_end_i(cyc_end_i),
    .fault_o  (fault_o),
    .avg_q    (avg_q)
);

// File: tb/test_crest_fault_detector.sv
// Directed bench for crest_fault_detector (default parameters).
module test_crest_fault_detector;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_i = 1'b0;
    logic         smp_valid_i = 1'b0;
    logic [W-1:0] smp_i = '0;
    logic         cyc_end_i = 1'b0;
    logic         fault_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    crest_fault_detector i_crest_fault_detector (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .smp_valid_i(smp_valid_i),
        .smp_i(smp_i), .cyc_end_i(cyc_end_i), .fault_o(fault_o)
    );

    always #4 clk = ~clk;  // 125 MHz

    // Drive one clock's worth of inputs at the falling edge.
    task automatic step(input logic v, input logic [W-1:0] s, input logic c);
        @(negedge clk);
        smp_valid_i = v; smp_i = s; cyc_end_i = c;
    endtask

    // Idle one clock so the boundary edge has passed, then compare fault_o.
    task automatic check(input string req, input logic exp);
        step(1'b0, '0, 1'b0);
        n_chk++;
        if (fault_o !== exp) begin
            n_bad++;
            $display("FAIL %s: fault_o=%b expected %b", req, fault_o, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en_i = 1'b0; smp_valid_i = 1'b0; cyc_end_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // n samples of value v, then a boundary that carries one more v.
    task automatic run_cycle(input logic [W-1:0] v, input int n);
        for (int i = 0; i < n; i++) step(1'b1, v, 1'b0);
        step(1'b1, v, 1'b1);
    endtask

    // Bring the average to exactly v: 10 cycles of 16 samples, then armed.
    task automatic settle(input logic [W-1:0] v);
        for (int k = 0; k < 10; k++) run_cycle(v, 15);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset", 1'b0);
    endtask

    task automatic t_warmup();
        do_reset();
        en_i = 1'b1;
        step(1'b1, 12'd100, 1'b1);  check("R6 boundary 1 unarmed", 1'b0);
        step(1'b1, 12'd100, 1'b1);  check("R6 boundary 2 unarmed", 1'b0);
        step(1'b1, 12'd100, 1'b1);  check("R6 boundary 3 unarmed", 1'b0);
        step(1'b1, 12'd2000, 1'b1); check("R6 boundary 4 unarmed", 1'b0);
        step(1'b1, 12'd4095, 1'b1); check("R6 boundary 5 armed trip", 1'b1);
    endtask

    // Threshold test at scale m: the average settles to 100*m.
    task automatic t_ratio(input int m, input string tag);
        do_reset();
        en_i = 1'b1;
        settle(W'(100 * m));
        check({tag, " steady no trip"}, 1'b0);
        // R3: a large sample with valid low must be ignored
        for (int i = 0; i < 4; i++) step(1'b0, 12'd4095, 1'b0);
        step(1'b1, W'(550 * m), 1'b1);
        check({tag, " R2 equality no trip (R3 invalid ignored)"}, 1'b0);
        settle(W'(100 * m));
        step(1'b1, W'(550 * m + 1), 1'b1);
        check({tag, " R2 one above trips"}, 1'b1);
        run_cycle(W'(100 * m), 8);
        en_i = 1'b0;
        step(1'b0, '0, 1'b0);
        check({tag, " R8 sticky"}, 1'b1);
    endtask

    task automatic t_disable();
        do_reset();
        en_i = 1'b1;
        settle(12'd100);
        en_i = 1'b0;
        for (int i = 0; i < 5; i++) step(1'b1, 12'd4095, 1'b1);
        check("R7 disabled ignores", 1'b0);
        en_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(1'b0, '0, 1'b1);
            check("R6 rewarm unarmed", 1'b0);
        end
        step(1'b1, 12'd1, 1'b1);
        check("R5 average cleared by disable", 1'b1);
    endtask

    task automatic t_peak_clear();
        do_reset();
        en_i = 1'b1;
        for (int k = 0; k < 3; k++) run_cycle(12'd100, 39);
        for (int i = 0; i < 39; i++) step(1'b1, 12'd100, 1'b0);
        step(1'b1, 12'd4095, 1'b1);  // boundary 4, unarmed
        check("R4 unarmed spike", 1'b0);
        run_cycle(12'd100, 15);
        check("R4 spike not carried", 1'b0);
    endtask

    initial begin
        t_reset();
        t_warmup();
        t_ratio(1, "R9 x1");
        t_ratio(4, "R9 x4");
        t_disable();
        t_peak_clear();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule